// File: doc/BRIEF.md
# Floating-Point Register Store-Multiple Sequencer

This block carries out an already-decoded store-multiple of 64-bit floating-point registers. A one-cycle `start` pulse presents the operation's fields: the base address, the P, U and W flags, the index of the general-purpose base register, the two fields that make up the first register index, the 8-bit immediate and the endianness. The block checks the fields and, if they are legal, walks the register list. It reads each doubleword through a combinational register-file port and writes it to memory as two 32-bit words, one word per accepted handshake.

A legal operation ends with a one-cycle `done` pulse. While `done` is high, the block presents the base value to write back and a flag that says whether write-back applies. If the fields do not form this operation, or form an unpredictable case, the block issues no memory write. It raises the matching error flag for one cycle and returns to idle. The block does not evaluate conditions, perform enable or trap checks, or handle memory faults.

Top module: `fp_stm_seq`

## Requirements
- R1: A legal operation writes exactly 2*(imm>>1) words. It reads registers with consecutive indices, starting at {sel_hi, sel_lo} with sel_hi as the top bit. Two words come from each register.
- R2: With u_bit=1, the first word address is `base`. Every following word address is 4 higher than the one before.
- R3: With u_bit=0, the first word address is base - imm*4. Every following word address is 4 higher than the one before.
- R4: With big_end=0, bits 31:0 of each register are written first and bits 63:32 second. With big_end=1, the order is reversed.
- R5: When `done` is high, wb_en equals the W flag of the operation. wb_value equals base + imm*4 when u_bit=1 and base - imm*4 when u_bit=0.
- R6: Only the {P,U,W} values 010, 011 and 101 are legal. Any other value raises err_mode for one cycle and produces no memory write.
- R7: err_unpred is raised for one cycle, with no memory write, when imm>>1 is 0, when it exceeds 16, or when start index + (imm>>1) exceeds 32.
- R8: err_unpred is raised when imm[0]=1 and start index + (imm>>1) exceeds 16. When the sum is at most 16, imm[0] has no effect on the operation.
- R9: err_unpred is raised when base_reg=15 and w_bit=1. base_reg=15 with w_bit=0 is legal.
- R10: While mem_valid=1 and mem_ready=0, mem_valid, mem_addr and mem_data hold their values into the next cycle.
- R11: `done` is a single-cycle pulse in the cycle after the last word is accepted. A `start` pulse received while an operation is running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that presents an operation; sampled only while idle |
| base | input | ADDR_W | Base address value |
| p_bit | input | 1 | P flag |
| u_bit | input | 1 | U flag: 1 adds, 0 decrements before |
| w_bit | input | 1 | W flag: write-back requested |
| base_reg | input | 4 | Index of the base general-purpose register |
| sel_hi | input | 1 | Top bit of the first register index |
| sel_lo | input | IDX_W-1 | Lower bits of the first register index |
| imm | input | IMM_W | Immediate count field |
| big_end | input | 1 | 1 selects big-endian word order |
| rf_idx | output | IDX_W | Register-file read index |
| rf_data | input | REG_W | Register-file read data for rf_idx |
| mem_valid | output | 1 | A memory word write is pending |
| mem_addr | output | ADDR_W | Word write address |
| mem_data | output | REG_W/2 | Word write data |
| mem_ready | input | 1 | Memory accepts the pending word |
| done | output | 1 | Pulse: operation complete |
| wb_en | output | 1 | Write-back applies; valid with done |
| wb_value | output | ADDR_W | Written-back base; valid with done |
| err_mode | output | 1 | Pulse: flag combination not this operation |
| err_unpred | output | 1 | Pulse: unpredictable field combination |

## Verification
The bench builds the block with its default parameters: 32-bit addresses, 64-bit registers, a file of 32 registers and an 8-bit immediate. With these values the full register file can be reached. The bench can therefore test a 16-register transfer that ends exactly at index 31 and the d+count=32 boundary. It can also test the 16-register limit on the low bank that applies when the immediate is odd. A random ready pattern produces long stalls, so the bench also covers the hold rule and the word ordering across stalls.

// File: rtl/fpstm_pkg.sv
package fpstm_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_t;
  localparam int unsigned PC_REG = 15;
endpackage

// File: rtl/fpstm_legal.sv
module fpstm_legal #(
  parameter int IDX_W    = 5,
  parameter int IMM_W    = 8,
  parameter int NUM_REGS = 32
) (
  input  logic             p_bit,
  input  logic             u_bit,
  input  logic             w_bit,
  input  logic [3:0]       base_reg,
  input  logic [IDX_W-1:0] first_idx,
  input  logic [IMM_W-1:0] imm,
  output logic             mode_bad,
  output logic             unpred,
  output logic [IMM_W-2:0] count
);
  localparam int SW = IMM_W + IDX_W;
  localparam logic [SW-1:0] HALF_FILE = SW'(NUM_REGS / 2);
  localparam logic [SW-1:0] FULL_FILE = SW'(NUM_REGS);

  logic [SW-1:0] span_end;
  logic [SW-1:0] cnt_w;

  always_comb begin
    count    = imm[IMM_W-1:1];
    cnt_w    = SW'(count);
    span_end = SW'(first_idx) + cnt_w;
    mode_bad = !((!p_bit && u_bit) || (p_bit && !u_bit && w_bit));
    unpred   = (count == '0) || (cnt_w > HALF_FILE) || (span_end > FULL_FILE)
             || (imm[0] && (span_end > HALF_FILE))
             || ((base_reg == 4'(fpstm_pkg::PC_REG)) && w_bit);
  end
endmodule

// File: rtl/fpstm_order.sv
module fpstm_order #(
  parameter int REG_W = 64
) (
  input  logic [REG_W-1:0]   reg_val,
  input  logic               second,
  input  logic               big_end,
  output logic [REG_W/2-1:0] word
);
  localparam int WW = REG_W / 2;
  logic take_upper;
  always_comb begin
    take_upper = second ^ big_end;
    word = take_upper ? reg_val[REG_W-1:WW] : reg_val[WW-1:0];
  end
endmodule

// File: rtl/fp_stm_seq.sv
module fp_stm_seq #(
  parameter int ADDR_W   = 32,
  parameter int REG_W    = 64,
  parameter int NUM_REGS = 32,
  parameter int IMM_W    = 8,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic              p_bit,
  input  logic              u_bit,
  input  logic              w_bit,
  input  logic [3:0]        base_reg,
  input  logic              sel_hi,
  input  logic [IDX_W-2:0]  sel_lo,
  input  logic [IMM_W-1:0]  imm,
  input  logic              big_end,
  output logic [IDX_W-1:0]  rf_idx,
  input  logic [REG_W-1:0]  rf_data,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [REG_W/2-1:0] mem_data,
  input  logic              mem_ready,
  output logic              done,
  output logic              wb_en,
  output logic [ADDR_W-1:0] wb_value,
  output logic              err_mode,
  output logic              err_unpred
);
  import fpstm_pkg::*;

  localparam int CNT_W = IMM_W - 1;
  localparam logic [ADDR_W-1:0] STEP_B = ADDR_W'(REG_W / 16);

  seq_state_t        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              half_q, half_d;
  logic              be_q, be_d;
  logic              wben_q, wben_d;
  logic [ADDR_W-1:0] wbv_q, wbv_d;
  logic              done_q, done_d;
  logic              errm_q, errm_d;
  logic              erru_q, erru_d;

  logic              mode_bad, unpred;
  logic [CNT_W-1:0]  count;
  logic [IDX_W-1:0]  first_idx;
  logic [ADDR_W-1:0] xfer;
  logic              accept;

  assign first_idx = {sel_hi, sel_lo};
  assign xfer      = ADDR_W'(imm) * STEP_B;
  assign accept    = (st_q == ST_RUN) && mem_ready;

  fpstm_legal #(.IDX_W(IDX_W), .IMM_W(IMM_W), .NUM_REGS(NUM_REGS)) u_legal (
    .p_bit(p_bit), .u_bit(u_bit), .w_bit(w_bit), .base_reg(base_reg),
    .first_idx(first_idx), .imm(imm),
    .mode_bad(mode_bad), .unpred(unpred), .count(count)
  );

  fpstm_order #(.REG_W(REG_W)) u_order (
    .reg_val(rf_data), .second(half_q), .big_end(be_q), .word(mem_data)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    idx_d  = idx_q;
    left_d = left_q;
    half_d = half_q;
    be_d   = be_q;
    wben_d = wben_q;
    wbv_d  = wbv_q;
    done_d = 1'b0;
    errm_d = 1'b0;
    erru_d = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          if (mode_bad || unpred) begin
            errm_d = mode_bad;
            erru_d = unpred;
          end else begin
            st_d   = ST_RUN;
            addr_d = u_bit ? base : (base - xfer);
            idx_d  = first_idx;
            left_d = count;
            half_d = 1'b0;
            be_d   = big_end;
            wben_d = w_bit;
            wbv_d  = u_bit ? (base + xfer) : (base - xfer);
          end
        end
      end
      ST_RUN: begin
        if (accept) begin
          addr_d = addr_q + STEP_B;
          half_d = ~half_q;
          if (half_q) begin
            idx_d  = idx_q + IDX_W'(1);
            left_d = left_q - CNT_W'(1);
            if (left_q == CNT_W'(1)) begin
              st_d   = ST_IDLE;
              done_d = 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      left_q <= '0;
      half_q <= 1'b0;
      be_q   <= 1'b0;
      wben_q <= 1'b0;
      wbv_q  <= '0;
      done_q <= 1'b0;
      errm_q <= 1'b0;
      erru_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
      left_q <= left_d;
      half_q <= half_d;
      be_q   <= be_d;
      wben_q <= wben_d;
      wbv_q  <= wbv_d;
      done_q <= done_d;
      errm_q <= errm_d;
      erru_q <= erru_d;
    end
  end

  assign rf_idx     = idx_q;
  assign mem_valid  = (st_q == ST_RUN);
  assign mem_addr   = addr_q;
  assign done       = done_q;
  assign wb_en      = wben_q;
  assign wb_value   = wbv_q;
  assign err_mode   = errm_q;
  assign err_unpred = erru_q;
endmodule

// File: rtl/fpstm_chk.sv
module fpstm_chk #(
  parameter int ADDR_W = 32,
  parameter int WW     = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WW-1:0]     mem_data,
  input logic              done,
  input logic              err_mode,
  input logic              err_unpred
);
  // R10
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || (mem_addr == $past(mem_addr) + ADDR_W'(4))));

  // R6
  no_write_on_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_mode || err_unpred) |-> !mem_valid);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!mem_valid && !err_mode && !err_unpred));
endmodule

bind fp_stm_seq fpstm_chk #(.ADDR_W(ADDR_W), .WW(REG_W/2)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .done(done),
  .err_mode(err_mode), .err_unpred(err_unpred)
);

// File: tb/fp_stm_seq_bench.sv
module fp_stm_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, start;
  logic [31:0] base;
  logic        p_bit, u_bit, w_bit, sel_hi, big_end, mem_ready;
  logic [3:0]  base_reg, sel_lo;
  logic [7:0]  imm;
  logic [4:0]  rf_idx;
  logic [63:0] rf_data;
  logic        mem_valid, done, wb_en, err_mode, err_unpred;
  logic [31:0] mem_addr, mem_data, wb_value;

  int total, bad, wcount;
  bit rmode, finished;
  logic [15:0] lfsr;
  logic [63:0] expq[$];
  bit          prev_stall;
  logic [31:0] prev_addr, prev_data;

  function automatic logic [63:0] regval(input int i);
    return {16'hA500 + 16'(i), 16'h1357, 16'h5A00 + 16'(i), 16'h2468};
  endfunction

  assign rf_data = regval(int'(rf_idx));

  fp_stm_seq u_fp_stm_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .base(base), .p_bit(p_bit),
    .u_bit(u_bit), .w_bit(w_bit), .base_reg(base_reg), .sel_hi(sel_hi),
    .sel_lo(sel_lo), .imm(imm), .big_end(big_end), .rf_idx(rf_idx),
    .rf_data(rf_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_ready(mem_ready), .done(done), .wb_en(wb_en),
    .wb_value(wb_value), .err_mode(err_mode), .err_unpred(err_unpred)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: drive ready, then compare every accepted word
  always @(negedge clk) begin
    if (rmode) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      mem_ready = lfsr[0];
    end else mem_ready = 1'b1;
    #1;
    if (rst_n) begin
      if (prev_stall)
        chk(mem_valid && mem_addr == prev_addr && mem_data == prev_data, "R10 hold",
            {mem_addr, mem_data}, {prev_addr, prev_data});
      prev_stall = mem_valid && !mem_ready;
      prev_addr  = mem_addr;
      prev_data  = mem_data;
      if (mem_valid && mem_ready) begin
        wcount++;
        if (expq.size() == 0) chk(1'b0, "R1 unexpected word", {mem_addr, mem_data}, 64'h0);
        else begin
          logic [63:0] e;
          e = expq.pop_front();
          chk({mem_addr, mem_data} == e, "R1 R2 R3 R4 word", {mem_addr, mem_data}, e);
        end
      end
    end
  end

  task automatic run_op(input logic [31:0] b, input logic [2:0] puw, input logic [3:0] rn,
                        input int d, input logic [7:0] im, input bit be, input bit poke,
                        input string tag);
    int cnt, sum;
    bit exp_mode, exp_unp;
    logic [31:0] a, exp_wb;
    cnt = int'(im) / 2;
    sum = d + cnt;
    exp_mode = !((puw[2:1] == 2'b01) || (puw == 3'b101));
    exp_unp  = (cnt == 0) || (cnt > 16) || (sum > 32) || (im[0] && sum > 16) || (rn == 4'd15 && puw[0]);
    a      = puw[1] ? b : b - 32'(im) * 4;
    exp_wb = puw[1] ? b + 32'(im) * 4 : b - 32'(im) * 4;
    if (!exp_mode && !exp_unp)
      for (int r = 0; r < cnt; r++) begin
        logic [63:0] v;
        v = regval(d + r);
        expq.push_back({a, be ? v[63:32] : v[31:0]});
        expq.push_back({a + 32'd4, be ? v[31:0] : v[63:32]});
        a = a + 32'd8;
      end
    wcount = 0;
    @(negedge clk);
    base = b; {p_bit, u_bit, w_bit} = puw; base_reg = rn;
    {sel_hi, sel_lo} = 5'(d); imm = im; big_end = be; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    #2;
    for (int k = 0; k < 400 && !(done || err_mode || err_unpred); k++) begin
      @(negedge clk);
      if (poke && k == 2) begin
        {p_bit, u_bit, w_bit} = 3'b111; imm = 8'd0; start = 1'b1;
      end else start = 1'b0;
      #2;
    end
    chk(err_mode == exp_mode, {tag, " R6 err_mode"}, 64'(err_mode), 64'(exp_mode));
    chk(err_unpred == exp_unp, {tag, " R7 R8 R9 err_unpred"}, 64'(err_unpred), 64'(exp_unp));
    if (exp_mode || exp_unp) begin
      chk(wcount == 0 && !mem_valid, {tag, " R6 no write"}, 64'(wcount), 64'h0);
    end else begin
      chk(done == 1'b1, {tag, " R11 done"}, 64'(done), 64'h1);
      chk(expq.size() == 0 && wcount == 2 * cnt, {tag, " R1 count"}, 64'(wcount), 64'(2 * cnt));
      chk(wb_en == puw[0], {tag, " R5 wb_en"}, 64'(wb_en), 64'(puw[0]));
      chk(wb_value == exp_wb, {tag, " R5 wb_value"}, 64'(wb_value), 64'(exp_wb));
    end
    @(negedge clk);
    #2;
    chk(!done && !err_mode && !err_unpred, {tag, " R11 pulse"}, {61'h0, done, err_mode, err_unpred}, 64'h0);
    expq.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    total = 0; bad = 0; wcount = 0; rmode = 1'b0; lfsr = 16'hACE1;
    prev_stall = 1'b0; finished = 1'b0;
    rst_n = 1'b0; start = 1'b0; base = '0; {p_bit, u_bit, w_bit} = 3'b0;
    base_reg = '0; sel_hi = 1'b0; sel_lo = '0; imm = '0; big_end = 1'b0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!mem_valid && !done && !err_mode && !err_unpred, "reset R11",
        {60'h0, mem_valid, done, err_mode, err_unpred}, 64'h0);
    rst_n = 1'b1;
    // R2 R4 increment, little endian, no write-back
    run_op(32'h0000_1000, 3'b010, 4'd2, 0, 8'd4, 1'b0, 1'b0, "ia_le");
    rmode = 1'b1;
    // R2 R4 R5 increment with write-back, big endian, stalls R10
    run_op(32'h0000_3000, 3'b011, 4'd3, 3, 8'd6, 1'b1, 1'b0, "ia_be_wb");
    // R3 decrement-before, 16 regs ending at index 31
    run_op(32'h0000_2000, 3'b101, 4'd1, 16, 8'd32, 1'b0, 1'b0, "db_full");
    // R8 odd imm within low bank
    run_op(32'h0000_4000, 3'b011, 4'd4, 2, 8'd9, 1'b1, 1'b0, "odd_low");
    // R6 illegal flag combinations
    run_op(32'h0, 3'b000, 4'd0, 0, 8'd4, 1'b0, 1'b0, "puw000");
    run_op(32'h0, 3'b111, 4'd0, 0, 8'd4, 1'b0, 1'b0, "puw111");
    run_op(32'h0, 3'b100, 4'd0, 0, 8'd4, 1'b0, 1'b0, "puw100");
    run_op(32'h0, 3'b001, 4'd0, 0, 8'd4, 1'b0, 1'b0, "puw001");
    // R7 count limits
    run_op(32'h0, 3'b010, 4'd0, 0, 8'd1, 1'b0, 1'b0, "cnt0");
    run_op(32'h0, 3'b010, 4'd0, 0, 8'd34, 1'b0, 1'b0, "cnt17");
    run_op(32'h0, 3'b010, 4'd0, 20, 8'd26, 1'b0, 1'b0, "span33");
    // R8 odd imm beyond low bank
    run_op(32'h0, 3'b010, 4'd0, 14, 8'd9, 1'b0, 1'b0, "odd_span18");
    // R9 base register 15
    run_op(32'h0, 3'b011, 4'd15, 0, 8'd4, 1'b0, 1'b0, "pc_wb");
    run_op(32'h0000_5000, 3'b010, 4'd15, 5, 8'd4, 1'b0, 1'b0, "pc_nowb");
    // R11 start while running is ignored
    run_op(32'h0000_6000, 3'b101, 4'd6, 8, 8'd8, 1'b1, 1'b1, "busy_poke");
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule